// File: doc/BRIEF.md
# Four-Plane Video Memory Write Path

This block sits between a CPU byte-write port and a video memory split into four bit planes that share one byte address. For every CPU write it forms one byte for each plane, merges that byte with the plane's latch byte under a pixel mask, and issues the write to the planes that are enabled. The latch bytes come from the read side, which holds the last byte fetched from each plane. Masked pixel positions are therefore refilled from the latches, because no plane can change single bits in place.

Two write modes are supported. In the direct mode, each plane takes the CPU byte rotated right by a programmable count, or a solid byte from its per-plane fill bit. The result is then combined with the latch by pass, AND, OR or XOR. In the copy mode, the CPU data is ignored and every enabled plane takes its own latch byte. A single read followed by a single write thus moves four bytes inside video memory.

A small two-state machine controls the output. It stays in `ST_IDLE` until it accepts a write, then moves to `ST_COMMIT`. In `ST_COMMIT` it drives the captured plane writes for one cycle. It returns to `ST_IDLE` when no new write is accepted, or stays in `ST_COMMIT` when writes come back to back. The settings are loaded all at once through `cfg_load`.

Top module: `planar_wr_path`

## Requirements
- R1: After reset the settings are write mode 0, plane enable 0xF, pixel mask 0xFF, rotate 0, function pass and no plane fill, so a write stores the CPU byte unchanged in all four planes; while reset is held and before any write, `plane_we` is 0.
- R2: A write strobed on `cpu_we` at a clock edge appears on the plane outputs for exactly the following cycle, with `plane_addr` equal to the CPU address for every enabled plane; a cycle without a strobe gives `plane_we` = 0.
- R3: Bit p of the 4-bit plane enable (`cfg_map`) gates plane p, so `plane_we` equals the enable value on each accepted write; the value 0x8 writes plane 3 alone.
- R4: In write mode 1, each enabled plane p receives latch byte p (`latch_bytes[8p+7:8p]`), whatever the CPU data, pixel mask, rotate, function and fill settings are.
- R5: In write mode 0, a plane without fill receives the CPU byte rotated right by the count held in bits 2–0 of `cfg_rotfn`.
- R6: In write mode 0, a plane whose bit in `cfg_fill_en` is 1 receives eight copies of its bit in `cfg_fill`, in place of the rotated CPU data.
- R7: The function field in bits 4–3 of `cfg_rotfn` combines the mode 0 byte with the plane's latch: 00 passes it, 01 ANDs, 10 ORs, 11 XORs.
- R8: In write mode 0, where a pixel mask bit is 1 the bit takes the computed value and where it is 0 the bit keeps the latch value; one mask serves all four planes.
- R9: The write mode field is `cfg_wmode[1:0]`; while it holds 2 or 3, a CPU write produces no plane write.
- R10: A settings load in the same cycle as a CPU write leaves that write on the old settings; the new settings apply from the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load all setting inputs below |
| cfg_wmode | input | 2 | Write mode field |
| cfg_rotfn | input | 5 | Rotate count [2:0], function select [4:3] |
| cfg_map | input | 4 | Plane enable, one bit per plane |
| cfg_bitmask | input | 8 | Pixel mask, 1 = computed bit, 0 = latch bit |
| cfg_fill | input | 4 | Per-plane fill bit |
| cfg_fill_en | input | 4 | Per-plane fill enable |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | AW (16) | CPU byte address |
| cpu_data | input | 8 | CPU write data |
| latch_bytes | input | 32 | Latch byte of plane p at [8p+7:8p] |
| plane_we | output | 4 | Plane write enables |
| plane_addr | output | AW (16) | Byte address shared by all planes |
| plane_wdata | output | 32 | Write byte of plane p at [8p+7:8p] |

## Verification
The assertions assume that `cpu_we`, the address, the CPU data and the latch bytes are stable around the sampling edge. They also assume that the latch bytes offered with a write are the ones that should be merged in that same cycle. A settings load may coincide with a write, and the properties sample the stored settings, not the load inputs, for that reason. The stimulus changes every input only at the falling clock edge and presents the latch bytes together with each strobe. It also sweeps modes 2 and 3, every rotate count, every function, fill combinations and mask patterns, including all-zero and all-one masks.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } fn_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } st_e;

    localparam logic [1:0] WM_DIRECT = 2'd0;
    localparam logic [1:0] WM_COPY   = 2'd1;

endpackage

// File: rtl/pwp_cfg_regs.sv
module pwp_cfg_regs #(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    localparam int RW     = $clog2(DW),
    localparam int FW     = RW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [1:0]         cfg_wmode,
    input  logic [FW-1:0]      cfg_rotfn,
    input  logic [NPLANES-1:0] cfg_map,
    input  logic [DW-1:0]      cfg_bitmask,
    input  logic [NPLANES-1:0] cfg_fill,
    input  logic [NPLANES-1:0] cfg_fill_en,
    output logic [1:0]         wmode,
    output logic [RW-1:0]      rot,
    output pwp_pkg::fn_e       fn,
    output logic [NPLANES-1:0] map,
    output logic [DW-1:0]      bitmask,
    output logic [NPLANES-1:0] fill,
    output logic [NPLANES-1:0] fill_en
);
    logic [FW-1:0] rotfn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmode   <= pwp_pkg::WM_DIRECT;
            rotfn_q <= '0;
            map     <= '1;
            bitmask <= '1;
            fill    <= '0;
            fill_en <= '0;
        end else if (cfg_load) begin
            wmode   <= cfg_wmode;
            rotfn_q <= cfg_rotfn;
            map     <= cfg_map;
            bitmask <= cfg_bitmask;
            fill    <= cfg_fill;
            fill_en <= cfg_fill_en;
        end
    end

    assign rot = rotfn_q[RW-1:0];
    assign fn  = pwp_pkg::fn_e'(rotfn_q[FW-1:RW]);

endmodule

// File: rtl/pwp_plane_alu.sv
module pwp_plane_alu #(
    parameter int DW = 8,
    localparam int RW = $clog2(DW)
) (
    input  logic [1:0]    wmode,
    input  logic [RW-1:0] rot,
    input  pwp_pkg::fn_e  fn,
    input  logic          fill_bit,
    input  logic          fill_en,
    input  logic [DW-1:0] bitmask,
    input  logic [DW-1:0] cpu_data,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] result
);
    logic [DW-1:0] rotated;
    logic [DW-1:0] src;
    logic [DW-1:0] combined;

    // right rotation: duplicate the byte and shift, keep the low half
    assign rotated = DW'({cpu_data, cpu_data} >> rot);

    always_comb begin
        src = fill_en ? {DW{fill_bit}} : rotated;
        unique case (fn)
            pwp_pkg::FN_PASS: combined = src;
            pwp_pkg::FN_AND:  combined = src & latch;
            pwp_pkg::FN_OR:   combined = src | latch;
            pwp_pkg::FN_XOR:  combined = src ^ latch;
        endcase
        if (wmode == pwp_pkg::WM_COPY)
            result = latch;
        else
            result = (combined & bitmask) | (latch & ~bitmask);
    end

endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path #(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    parameter int AW      = 16,
    localparam int RW     = $clog2(DW),
    localparam int FW     = RW + 2,
    localparam int BW     = NPLANES * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [1:0]         cfg_wmode,
    input  logic [FW-1:0]      cfg_rotfn,
    input  logic [NPLANES-1:0] cfg_map,
    input  logic [DW-1:0]      cfg_bitmask,
    input  logic [NPLANES-1:0] cfg_fill,
    input  logic [NPLANES-1:0] cfg_fill_en,
    input  logic               cpu_we,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [DW-1:0]      cpu_data,
    input  logic [BW-1:0]      latch_bytes,
    output logic [NPLANES-1:0] plane_we,
    output logic [AW-1:0]      plane_addr,
    output logic [BW-1:0]      plane_wdata
);
    import pwp_pkg::*;

    logic [1:0]         wmode_w;
    logic [RW-1:0]      rot_w;
    fn_e                fn_w;
    logic [NPLANES-1:0] map_w;
    logic [DW-1:0]      bm_w;
    logic [NPLANES-1:0] fill_w;
    logic [NPLANES-1:0] fill_en_w;
    logic [BW-1:0]      merged;

    st_e                state_q, state_d;
    logic               accept;
    logic [NPLANES-1:0] we_q;
    logic [AW-1:0]      addr_q;
    logic [BW-1:0]      data_q;

    pwp_cfg_regs #(.NPLANES(NPLANES), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_wmode  (cfg_wmode),
        .cfg_rotfn  (cfg_rotfn),
        .cfg_map    (cfg_map),
        .cfg_bitmask(cfg_bitmask),
        .cfg_fill   (cfg_fill),
        .cfg_fill_en(cfg_fill_en),
        .wmode      (wmode_w),
        .rot        (rot_w),
        .fn         (fn_w),
        .map        (map_w),
        .bitmask    (bm_w),
        .fill       (fill_w),
        .fill_en    (fill_en_w)
    );

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        pwp_plane_alu #(.DW(DW)) u_alu (
            .wmode   (wmode_w),
            .rot     (rot_w),
            .fn      (fn_w),
            .fill_bit(fill_w[p]),
            .fill_en (fill_en_w[p]),
            .bitmask (bm_w),
            .cpu_data(cpu_data),
            .latch   (latch_bytes[p*DW +: DW]),
            .result  (merged[p*DW +: DW])
        );
    end

    // only the direct and copy modes produce a plane write
    assign accept = cpu_we && (wmode_w == WM_DIRECT || wmode_w == WM_COPY);

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = accept ? ST_COMMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                we_q   <= map_w;
                addr_q <= cpu_addr;
                data_q <= merged;
            end
        end
    end

    always_comb begin
        plane_addr  = addr_q;
        plane_wdata = data_q;
        unique case (state_q)
            ST_IDLE:   plane_we = '0;
            ST_COMMIT: plane_we = we_q;
        endcase
    end

endmodule

// File: rtl/pwp_chk.sv
module pwp_chk #(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    parameter int AW      = 16,
    localparam int BW     = NPLANES * DW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_we,
    input logic [AW-1:0]      cpu_addr,
    input logic [BW-1:0]      latch_bytes,
    input logic [NPLANES-1:0] plane_we,
    input logic [AW-1:0]      plane_addr,
    input logic [BW-1:0]      plane_wdata,
    input logic [1:0]         wmode,
    input logic [NPLANES-1:0] map,
    input logic [DW-1:0]      bitmask
);
    // R2
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> plane_we == '0);

    // R2
    addr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !wmode[1]) |=> plane_addr == $past(cpu_addr));

    // R3
    enable_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !wmode[1]) |=> plane_we == $past(map));

    // R4
    copy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && wmode == 2'd1) |=> plane_wdata == $past(latch_bytes));

    // R8
    mask_zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && wmode == 2'd0 && bitmask == '0) |=> plane_wdata == $past(latch_bytes));

    // R9
    bad_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && wmode[1]) |=> plane_we == '0);

endmodule

bind planar_wr_path pwp_chk #(.NPLANES(NPLANES), .DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .latch_bytes(latch_bytes),
    .plane_we   (plane_we),
    .plane_addr (plane_addr),
    .plane_wdata(plane_wdata),
    .wmode      (wmode_w),
    .map        (map_w),
    .bitmask    (bm_w)
);

// File: tb/tb_planar_wr_path.sv
`timescale 1ns/1ps
module tb_planar_wr_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_wmode = '0;
    logic [4:0]  cfg_rotfn = '0;
    logic [3:0]  cfg_map = '0;
    logic [7:0]  cfg_bitmask = '0;
    logic [3:0]  cfg_fill = '0;
    logic [3:0]  cfg_fill_en = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [31:0] latch_bytes = '0;
    logic [3:0]  plane_we;
    logic [15:0] plane_addr;
    logic [31:0] plane_wdata;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    planar_wr_path dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wmode(cfg_wmode),
        .cfg_rotfn(cfg_rotfn), .cfg_map(cfg_map), .cfg_bitmask(cfg_bitmask),
        .cfg_fill(cfg_fill), .cfg_fill_en(cfg_fill_en), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .latch_bytes(latch_bytes),
        .plane_we(plane_we), .plane_addr(plane_addr), .plane_wdata(plane_wdata)
    );

    // behavioural reference settings and expected outputs
    logic [1:0] m_mode;
    logic [4:0] m_rotfn;
    logic [3:0] m_map, m_fill, m_fill_en;
    logic [7:0] m_bm;
    logic [3:0] e_we = '0;
    logic [15:0] e_addr = '0;
    logic [7:0] e_data [4];

    function automatic logic [7:0] model_byte(int p);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            logic lb, s, v;
            lb = latch_bytes[p*8 + b];
            if (m_mode == 2'd1) r[b] = lb;
            else begin
                if (m_fill_en[p]) s = m_fill[p];
                else s = cpu_data[(b + int'(m_rotfn[2:0])) % 8];
                case (m_rotfn[4:3])
                    2'd0: v = s;
                    2'd1: v = s & lb;
                    2'd2: v = s | lb;
                    default: v = s ^ lb;
                endcase
                r[b] = m_bm[b] ? v : lb;
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2'd0; m_rotfn = '0; m_map = 4'hF; m_bm = 8'hFF;
            m_fill = '0; m_fill_en = '0; e_we = '0;
        end else begin
            if (cpu_we && m_mode < 2'd2) begin
                e_we = m_map;
                e_addr = cpu_addr;
                for (int p = 0; p < 4; p++) e_data[p] = model_byte(p);
            end else e_we = '0;
            if (cfg_load) begin
                m_mode = cfg_wmode; m_rotfn = cfg_rotfn; m_map = cfg_map;
                m_bm = cfg_bitmask; m_fill = cfg_fill; m_fill_en = cfg_fill_en;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare against the reference on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, 32'(plane_we), 32'(e_we), "plane_we");
            for (int p = 0; p < 4; p++) begin
                if (e_we[p]) begin
                    check(cur_req, 32'(plane_addr), 32'(e_addr), "plane_addr");
                    check(cur_req, 32'(plane_wdata[p*8 +: 8]), 32'(e_data[p]), "plane byte");
                end
            end
        end
    end

    task automatic set_cfg(logic [1:0] wm, logic [4:0] rf, logic [3:0] mp,
                           logic [7:0] bm, logic [3:0] fl, logic [3:0] fe);
        @(negedge clk);
        cfg_load = 1'b1; cfg_wmode = wm; cfg_rotfn = rf; cfg_map = mp;
        cfg_bitmask = bm; cfg_fill = fl; cfg_fill_en = fe;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // one write, then leave the output visible at the returning edge
    task automatic write1(logic [15:0] a, logic [7:0] d, logic [31:0] l);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d; latch_bytes = l;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic burst(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_we = ($urandom % 4) != 0;
            cpu_addr = 16'($urandom); cpu_data = 8'($urandom);
            latch_bytes = $urandom;
        end
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", 32'(plane_we), 32'h0, "reset plane_we");
        rst_n = 1'b1;
        write1(16'h0198, 8'hA5, 32'h1234_5678);
        check("R1", 32'(plane_we), 32'hF, "default enables");
        check("R1", plane_wdata, 32'hA5A5_A5A5, "default data");

        cur_req = "R2";
        repeat (2) @(negedge clk);
        check("R2", 32'(plane_we), 32'h0, "no strobe");
        burst(40);

        cur_req = "R3";
        set_cfg(2'd0, 5'd0, 4'h8, 8'hFF, 4'h0, 4'h0);
        write1(16'h0040, 8'h3C, 32'h0);
        check("R3", 32'(plane_we), 32'h8, "plane 3 only");
        for (int m = 0; m < 16; m++) begin
            set_cfg(2'd0, 5'd0, 4'(m), 8'hFF, 4'h0, 4'h0);
            burst(4);
        end

        cur_req = "R4";
        set_cfg(2'd1, 5'b11_101, 4'hF, 8'h0F, 4'hA, 4'h5);
        write1(16'h1F40, 8'hFF, 32'hDEAD_BEEF);
        check("R4", plane_wdata, 32'hDEAD_BEEF, "copy from latches");
        burst(30);

        cur_req = "R5";
        for (int r = 0; r < 8; r++) begin
            set_cfg(2'd0, 5'(r), 4'hF, 8'hFF, 4'h0, 4'h0);
            burst(6);
        end
        set_cfg(2'd0, 5'd3, 4'hF, 8'hFF, 4'h0, 4'h0);
        write1(16'h0002, 8'h01, 32'h0);
        check("R5", 32'(plane_wdata[7:0]), 32'h20, "rotate right 3");

        cur_req = "R6";
        set_cfg(2'd0, 5'd0, 4'hF, 8'hFF, 4'b0101, 4'b0011);
        write1(16'h0003, 8'h5A, 32'h0);
        check("R6", plane_wdata, 32'h5A5A_00FF, "fill planes 0 and 1");
        for (int f = 0; f < 16; f++) begin
            set_cfg(2'd0, 5'(f % 8), 4'hF, 8'($urandom), 4'($urandom), 4'(f));
            burst(4);
        end

        cur_req = "R7";
        for (int f = 0; f < 4; f++) begin
            set_cfg(2'd0, {2'(f), 3'd0}, 4'hF, 8'hFF, 4'h0, 4'h0);
            burst(8);
        end
        set_cfg(2'd0, 5'b10_000, 4'hF, 8'hFF, 4'h0, 4'h0);
        write1(16'h0004, 8'h0F, 32'hF000_00F0);
        check("R7", plane_wdata, 32'hFF0F_0FFF, "OR with latch");

        cur_req = "R8";
        set_cfg(2'd0, 5'd0, 4'hF, 8'hF0, 4'h0, 4'h0);
        write1(16'h0005, 8'hFF, 32'h0000_0000);
        check("R8", plane_wdata, 32'hF0F0_F0F0, "mask upper nibble");
        for (int k = 0; k < 12; k++) begin
            set_cfg(2'd0, 5'($urandom), 4'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
            burst(5);
        end

        cur_req = "R9";
        set_cfg(2'd2, 5'd0, 4'hF, 8'hFF, 4'h0, 4'h0);
        write1(16'h0006, 8'h77, 32'h0);
        check("R9", 32'(plane_we), 32'h0, "mode 2 silent");
        set_cfg(2'd3, 5'd0, 4'hF, 8'hFF, 4'h0, 4'h0);
        burst(10);

        cur_req = "R10";
        set_cfg(2'd0, 5'd0, 4'hF, 8'hFF, 4'h0, 4'h0);
        @(negedge clk);
        cfg_load = 1'b1; cfg_wmode = 2'd1; cfg_rotfn = '0; cfg_map = 4'h1;
        cfg_bitmask = 8'hFF; cfg_fill = '0; cfg_fill_en = '0;
        cpu_we = 1'b1; cpu_addr = 16'h0007; cpu_data = 8'h42; latch_bytes = 32'h1111_1111;
        @(negedge clk);
        cfg_load = 1'b0; cpu_we = 1'b0;
        check("R10", 32'(plane_we), 32'hF, "old enables");
        check("R10", plane_wdata, 32'h4242_4242, "old mode");
        write1(16'h0008, 8'h42, 32'h1111_1199);
        check("R10", 32'(plane_we), 32'h1, "new enables");
        check("R10", 32'(plane_wdata[7:0]), 32'h99, "new mode");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule